// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives a row of twelve status LEDs through external serial parts. A free-running loop of 36 serial clock cycles repeats forever. In each cycle the block puts one bit on a serial data line, and the serial clock is made by dividing the system clock. The status word and the mode select are plain inputs. Both are sampled once at the first cycle of every frame, so a frame never mixes old and new status.

Mode 0 serves a display driver that expects a start bit. The frame holds a one, two zero pads, the twelve LED bits in true polarity, and zero pads after that. Mode 1 serves a chain of latching shift registers. The twelve LED bits go out inverted at the head of the frame and the filler is inverted as well. A latch strobe is raised during the low half of serial cycle 35, after the shifting is complete and before the next frame begins.

Top module: `led_serial_out`

## Requirements
- R1: While `rst` is high, `serClk`, `serData` and `serLatch` read low. On the first edge after release, the loop restarts at serial cycle 1, phase 0.
- R2: `serClk` has a period of DIV system clocks. It is low for the first DIV/2 (rounded down) of them and high for the rest.
- R3: A frame is 36 serial clock cycles long, and frames follow each other with no gap.
- R4: `serData` changes only at the start of a serial cycle, where `serClk` falls. It is stable across the rising edge of `serClk`.
- R5: In mode 0 (`modeSel`=0), serial cycle 1 carries a 1 (start bit), and cycles 2 and 3 carry 0.
- R6: In mode 0, serial cycles 4 to 15 carry `ledWord[0]` to `ledWord[11]` in true polarity.
- R7: In mode 0, serial cycles 16 to 36 carry 0, and `serLatch` stays low for the whole frame.
- R8: In mode 1 (`modeSel`=1), serial cycles 1 to 12 carry the inverse of `ledWord[0]` to `ledWord[11]`, and cycles 13 to 36 carry 1 (inverted zero filler).
- R9: In mode 1, `serLatch` is high only while `serClk` is low in serial cycle 35, which is once per frame.
- R10: `ledWord` and `modeSel` are sampled at the start of the frame. A change in the middle of a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ledWord | input | 12 | LED status, bit 0 is LED 1, 1 means on |
| modeSel | input | 1 | 0: start-bit driver framing, 1: latching chain framing |
| serClk | output | 1 | Divided serial clock |
| serData | output | 1 | Serial data |
| serLatch | output | 1 | Latch strobe (mode 1 only) |

## Verification
Every output is a register fed from the loop counters. The value for loop position p therefore appears one system clock after the edge at which the counters hold p, which is the first edge after reset release for p = 0. The bench keeps its own count of edges since reset release. It samples on the falling system clock edge, takes the position as that count minus one, and compares all three outputs against values computed from the requirements at every system clock of a frame. Input changes are driven on falling edges. The expected word and mode for a frame are the values present at the capture edge of position 0, and the mid-frame checks keep the old values until the next boundary.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  localparam int FRAME_LEN = 36;
  localparam int LED_BITS  = 12;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int M0_LED_FIRST = 3;   // cycle 4, zero based
  localparam int M1_LATCH_IDX = 34;  // cycle 35, zero based

  typedef struct packed {
    logic             frameStart;
    logic             clkHigh;
    logic [IDX_W-1:0] bitIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/led_ser_ctrl.sv
module led_ser_ctrl
  import led_ser_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  output ctlStrobe_t strobe
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      bitIdx <= '0;
    end else if (phase == PH_W'(DIV - 1)) begin
      phase  <= '0;
      bitIdx <= (bitIdx == IDX_W'(FRAME_LEN - 1)) ? '0 : bitIdx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobe.frameStart = (phase == '0) && (bitIdx == '0);
    strobe.clkHigh    = (phase >= PH_W'(HALF));
    strobe.bitIdx     = bitIdx;
  end
endmodule

// File: rtl/led_ser_path.sv
module led_ser_path
  import led_ser_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobe_t          strobe,
  input  logic [LED_BITS-1:0] ledWord,
  input  logic                modeSel,
  output logic                serClk,
  output logic                serData,
  output logic                serLatch
);
  logic [LED_BITS-1:0] wordReg;
  logic                modeReg;
  logic [LED_BITS-1:0] effWord;
  logic                effMode;
  logic                dataNext;
  logic                latchNext;

  assign effWord = strobe.frameStart ? ledWord : wordReg;
  assign effMode = strobe.frameStart ? modeSel : modeReg;

  always_comb begin
    if (!effMode) begin
      dataNext = (strobe.bitIdx == '0);
      for (int k = 0; k < LED_BITS; k++) begin
        if (strobe.bitIdx == IDX_W'(M0_LED_FIRST + k)) dataNext = effWord[k];
      end
      latchNext = 1'b0;
    end else begin
      dataNext = 1'b1;
      for (int k = 0; k < LED_BITS; k++) begin
        if (strobe.bitIdx == IDX_W'(k)) dataNext = ~effWord[k];
      end
      latchNext = (strobe.bitIdx == IDX_W'(M1_LATCH_IDX)) && !strobe.clkHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordReg  <= '0;
      modeReg  <= 1'b0;
      serClk   <= 1'b0;
      serData  <= 1'b0;
      serLatch <= 1'b0;
    end else begin
      if (strobe.frameStart) begin
        wordReg <= ledWord;
        modeReg <= modeSel;
      end
      serClk   <= strobe.clkHigh;
      serData  <= dataNext;
      serLatch <= latchNext;
    end
  end
endmodule

// File: rtl/led_serial_out.sv
module led_serial_out
  import led_ser_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] ledWord,
  input  logic        modeSel,
  output logic        serClk,
  output logic        serData,
  output logic        serLatch
);
  ctlStrobe_t strobe;

  led_ser_ctrl #(.DIV(DIV)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  led_ser_path u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .ledWord  (ledWord),
    .modeSel  (modeSel),
    .serClk   (serClk),
    .serData  (serData),
    .serLatch (serLatch)
  );
endmodule

// File: rtl/led_ser_chk.sv
module led_ser_chk (
  input logic clk,
  input logic rst,
  input logic serClk,
  input logic serData,
  input logic serLatch
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (serClk) armed <= 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!serClk && !serLatch));

  a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(serClk) |-> $stable(serData));

  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    (armed && !$stable(serData)) |-> $fell(serClk));

  a_r9_latch_low_phase: assert property (@(posedge clk) disable iff (rst)
    serLatch |-> !serClk);
endmodule

bind led_serial_out led_ser_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .serClk   (serClk),
  .serData  (serData),
  .serLatch (serLatch)
);

// File: tb/sim_led_serial_out.sv
module sim_led_serial_out;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int FRAME = 36;
  localparam int FSYS  = DIV * FRAME;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ledWord = '0;
  logic        modeSel = 1'b0;
  logic        serClk, serData, serLatch;

  int tick = 0;
  int nChecks = 0;
  int nFail = 0;

  led_serial_out #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .ledWord(ledWord), .modeSel(modeSel),
    .serClk(serClk), .serData(serData), .serLatch(serLatch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick <= 0;
    else tick <= tick + 1;
  end

  // expected {serClk, serData, serLatch} at loop position idx
  function automatic logic [2:0] expOut(int idx, logic [11:0] w, logic m);
    int ph = idx % DIV;
    int b  = idx / DIV;
    logic c = (ph >= DIV/2);
    logic d;
    logic l;
    if (!m) begin
      d = (b == 0) ? 1'b1 : ((b >= 3 && b <= 14) ? w[b-3] : 1'b0);
      l = 1'b0;
    end else begin
      d = (b < 12) ? ~w[b] : 1'b1;
      l = (b == 34) && (ph < DIV/2);
    end
    return {c, d, l};
  endfunction

  function automatic string reqOf(int idx, logic m, logic [2:0] act, logic [2:0] exp);
    int b = idx / DIV;
    if (act[2] !== exp[2]) return "R2";
    if (m && act[0] !== exp[0]) return "R9";
    if (!m) begin
      if (b < 3) return "R5";
      if (b < 15) return "R6";
      return "R7";
    end
    return "R8";
  endfunction

  task automatic checkSample(int idx, logic [11:0] w, logic m, string ctx);
    logic [2:0] act = {serClk, serData, serLatch};
    logic [2:0] exp = expOut(idx, w, m);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s (%s) pos=%0d actual=%b expected=%b",
               reqOf(idx, m, act, exp), ctx, idx, act, exp);
    end
  endtask

  // waits for the next frame start, then checks all positions of it (R3)
  task automatic checkFrame(logic [11:0] w, logic m, string ctx,
                            bit doMid, logic [11:0] midW, logic midM);
    @(negedge clk);
    while (((tick - 1) % FSYS) != 0) @(negedge clk);
    for (int i = 0; i < FSYS; i++) begin
      checkSample(i, w, m, ctx);
      if (doMid && i == FSYS/2) begin
        ledWord = midW;
        modeSel = midM;
      end
      @(negedge clk);
    end
  endtask

  task automatic testReset;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      nChecks++;
      if ({serClk, serData, serLatch} !== 3'b000) begin
        nFail++;
        $display("FAIL R1 reset outputs actual=%b expected=000",
                 {serClk, serData, serLatch});
      end
    end
    ledWord = 12'h3C1;
    modeSel = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      checkSample(i, 12'h3C1, 1'b0, "R1 restart");
    end
  endtask

  task automatic testMode0;
    logic [11:0] pats [5] = '{12'hA5C, 12'h000, 12'hFFF, 12'h001, 12'h800};
    for (int p = 0; p < 5; p++) begin
      ledWord = pats[p];
      modeSel = 1'b0;
      checkFrame(pats[p], 1'b0, "R5 R6 R7 mode0", 0, '0, 1'b0);
    end
  endtask

  task automatic testMode1;
    logic [11:0] pats [4] = '{12'h5A3, 12'h000, 12'hFFF, 12'h801};
    for (int p = 0; p < 4; p++) begin
      ledWord = pats[p];
      modeSel = 1'b1;
      checkFrame(pats[p], 1'b1, "R8 R9 mode1", 0, '0, 1'b0);
    end
  endtask

  task automatic testMidFrame;
    ledWord = 12'h0F0;
    modeSel = 1'b0;
    checkFrame(12'h0F0, 1'b0, "R10 hold mode0", 1, 12'hF0F, 1'b1);
    checkFrame(12'hF0F, 1'b1, "R10 next mode1", 0, '0, 1'b0);
    checkFrame(12'hF0F, 1'b1, "R10 hold mode1", 1, 12'h123, 1'b0);
    checkFrame(12'h123, 1'b0, "R10 next mode0", 0, '0, 1'b0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testMode0();
    testMode1();
    testMidFrame();
    summary();
  end
endmodule